// File: doc/BRIEF.md
# Programmable-Level Interrupt Priority Controller

This block merges 27 interrupt request lines coming from peripherals into one request toward a processor core. Each request line is already the combination of the causes that its peripheral has flagged and enabled, so the block sees one active-high input per source. Software gives every source a priority level from 0 to 7. Level 0 leaves the source disabled, and among the active sources the highest level wins.

The core receives three registered outputs: a request, the level of the winning source, and a vector number equal to a programmable base plus the winner's index. A small write-only configuration port loads the levels, three bits per source and eight sources per word, and loads the vector base. Level and vector are registered together, so they always change on the same clock edge.

Top module: `irq_level_arbiter`

## Requirements
- R1: After reset every source level is 0 and the vector base is 0. The outputs irq_o, level_o and vec_o are all 0, and they stay 0 for any req_i pattern until levels are programmed.
- R2: A source whose programmed level is 0 never wins and never raises irq_o, even while its req_i bit is high.
- R3: irq_o is 1 exactly when at least one source had req_i high and a nonzero level on the previous clock edge.
- R4: Among the active sources with nonzero level, the one with the numerically highest level wins, and level_o shows that level.
- R5: When several active sources share the highest level, the one with the lowest index wins.
- R6: vec_o equals the vector base plus the winner's index, taken modulo 256. The base is written at cfg_addr 4 from cfg_wdata[7:0].
- R7: While irq_o is 0, level_o and vec_o are both 0.
- R8: A write with cfg_addr = g (0 to 3) loads cfg_wdata[3k+2:3k] into the level of source 8g+k, for each k with 8g+k < 27. A write to cfg_addr 5, 6 or 7 changes no level and does not change the base.
- R9: The outputs reflect req_i and the configuration from one clock edge earlier. A configuration write sampled on one edge affects the outputs registered on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 27 | Combined request per source, bit i is source i |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Word address: 0-3 level groups, 4 vector base |
| cfg_wdata | input | 24 | Write data: eight 3-bit level fields, or the base in bits 7:0 |
| irq_o | output | 1 | Interrupt request to the core |
| level_o | output | 3 | Level of the winning source, 0 when idle |
| vec_o | output | 8 | Vector number of the winning source, 0 when idle |

## Verification
A corrupted level register shows up as a wrong winner, or a missing or spurious request, on the first clock edge after a matching request pattern is applied. A corrupted base register shows up in vec_o on that same edge. Ties at a shared level and masking by level 0 are set up on purpose, because a wrong comparison direction changes only which index appears on vec_o. A wrong group decode shows up after a write when a source in another group answers with a level it was never given.

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter #(
  parameter int NSRC = 27,
  parameter int LVLW = 3,
  parameter int VECW = 8,
  parameter int GRP  = 8,
  localparam int NGRP = (NSRC + GRP - 1) / GRP,
  localparam int AW   = $clog2(NGRP + 1),
  localparam int DW   = GRP * LVLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic            irq_o,
  output logic [LVLW-1:0] level_o,
  output logic [VECW-1:0] vec_o
);
  localparam int IDXW = $clog2(NSRC);

  logic [NSRC*LVLW-1:0] lvl_q;
  logic [VECW-1:0]      base_q;
  logic [IDXW-1:0]      win_q;
  logic [LVLW-1:0]      best_lvl;
  logic [IDXW-1:0]      best_idx;
  logic                 hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        lvl_q[i*LVLW +: LVLW] <= '0;
      else if (cfg_we && cfg_addr == AW'(i / GRP))
        lvl_q[i*LVLW +: LVLW] <= cfg_wdata[(i % GRP)*LVLW +: LVLW];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      base_q <= '0;
    else if (cfg_we && cfg_addr == AW'(NGRP))
      base_q <= cfg_wdata[VECW-1:0];

  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    hit      = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i] && lvl_q[i*LVLW +: LVLW] != '0 &&
          lvl_q[i*LVLW +: LVLW] >= best_lvl) begin
        best_lvl = lvl_q[i*LVLW +: LVLW];
        best_idx = IDXW'(i);
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_o   <= 1'b0;
      level_o <= '0;
      vec_o   <= '0;
      win_q   <= '0;
    end else begin
      irq_o   <= hit;
      level_o <= best_lvl;
      vec_o   <= hit ? base_q + VECW'(best_idx) : '0;
      win_q   <= best_idx;
    end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (level_o == '0 && vec_o == '0));

  // R3
  req_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> level_o != '0);

  // R4
  winner_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> |(($past(req_i) >> win_q) & NSRC'(1)));

  // R2
  winner_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> level_o == LVLW'($past(lvl_q) >> (win_q * LVLW)));
endmodule

// File: tb/tb_irq_level_arbiter.sv
`timescale 1ns/1ps
module tb_irq_level_arbiter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [26:0] req_i = '0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        irq_o;
  logic [2:0]  level_o;
  logic [7:0]  vec_o;
  int total = 0, bad = 0;
  bit done = 0;

  irq_level_arbiter dut (.*);

  always #2 clk = ~clk;

  localparam int LV [27] = '{1,3,0,7,2,5,3,4, 6,1,2,0,7,3,5,5,
                             1,2,3,4,5,6,7,1, 6,2,7};
  localparam int NV = 12;
  localparam logic [26:0] TREQ [NV] = '{
    27'h0, 27'h4, 27'h1, 27'h3, 27'h42, 27'h4001008,
    27'h4001000, 27'hC100, 27'hC000, 27'h4000800, 27'h7FFFFFF, 27'h804};
  localparam logic [11:0] TEXP [NV] = '{
    12'h000, 12'h000, 12'h940, 12'hB41, 12'hB41, 12'hF43,
    12'hF4C, 12'hE48, 12'hD4E, 12'hF5A, 12'hF43, 12'h000};
  localparam string TREQN [NV] = '{"R7","R2","R3","R4","R5","R5",
                                   "R5","R4","R4","R2","R4","R2"};

  function automatic logic [23:0] pack(input int g);
    logic [23:0] d = '0;
    for (int k = 0; k < 8; k++)
      d[3*k +: 3] = (8*g + k < 27) ? 3'(LV[8*g + k]) : 3'd7;
    return d;
  endfunction

  task automatic chk(input string r, input logic [11:0] exp);
    logic [11:0] got = {irq_o, level_o, vec_o};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got irq/lvl/vec=%h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic apply(input logic [26:0] r);
    req_i = r;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    req_i = '1;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 12'h000);
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 unprogrammed levels", 12'h000);

    for (int g = 0; g < 4; g++) wr(3'(g), pack(g));
    wr(3'd4, 24'h000040);

    for (int i = 0; i < NV; i++) begin
      apply(TREQ[i]);
      chk(TREQN[i], TEXP[i]);
    end

    // R9: one-edge latency
    apply(27'h0);
    req_i = 27'h8;
    @(posedge clk);
    #1 chk("R9 registered next edge", 12'hF43);

    // R8: lower src3 to level 0 via group 0 write, src12 (level 7) now wins
    @(negedge clk);
    req_i = '1;
    wr(3'd0, pack(0) & ~24'h000E00);
    @(negedge clk);
    chk("R8 group write", 12'hF4C);

    // R6: base wraps modulo 256
    wr(3'd4, 24'h0000F0);
    apply(27'h4000000);
    chk("R6 base wrap", 12'hF0A);

    // R8: address 5 ignored, base and levels unchanged
    wr(3'd5, 24'hFFFFFF);
    apply(27'h4000000);
    chk("R8 addr5 ignored", 12'hF0A);
    apply(27'h0000004);
    chk("R8 addr5 no level change", 12'h000);

    // R8/R2: group 1 write only affects sources 8..15
    wr(3'd1, 24'h0);
    apply(27'h000FF00);
    chk("R8 group1 cleared", 12'h000);
    apply(27'h001FF00);
    chk("R8 group2 kept", 12'h900);

    // R1: reset again clears levels
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    apply('1);
    @(negedge clk);
    chk("R1 reset clears levels", 12'h000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule